// File: doc/BRIEF.md
# MSI Capability Register File

This block holds the configuration-space registers of a message signalled interrupt capability for one PCI function. Software reaches it through a plain dword register port. The port carries a dword index counted from the capability base and four byte enables. Writes take effect at the clock edge. Reads return their data on the cycle after the request. The capability ID and next-pointer bytes at the base belong to the capability list logic, so they read as zero here.

Three build-time parameters shape the register set: the number of vectors the function can request, whether the message address has an upper dword, and whether vectors can be masked one by one. The block applies the write masks that follow from these choices and clamps an over-sized enabled vector count. It drops pending bits that lie outside the granted range. It also presents the enable state, the granted vector count and a request to deassert the legacy INTx line to the interrupt delivery logic. That delivery logic sets and clears pending bits through dedicated inputs.

Top module: `msi_cap_regs`

## Requirements
- R1: After reset, the enable bit, the enabled-count field, address low, address high, message data, the mask word and the pending word all read as zero. Dword 0 reads 0x0186_0000 with the default parameters (8 vectors, 64-bit, masking).
- R2: Dword 0 bits [15:0] read zero. Bits [19:17] hold log2 of NUM_VEC, bit 23 reflects ADDR64 and bit 24 reflects PVM. Writes never change these bits.
- R3: In dword 0, only bit 16 (enable) and bits [22:20] (enabled count, log2) are writable, both through byte enable 2. Bits [31:25] read zero.
- R4: Address low is dword 1, with bits [31:2] writable and bits [1:0] always zero. When ADDR64 is set, address high is dword 2 and is fully writable.
- R5: Message data is dword 3 when ADDR64 is set and dword 2 otherwise. Bits [15:0] are writable and bits [31:16] read zero.
- R6: The mask word follows the data dword. Only bits below NUM_VEC can be written, and all higher bits stay zero.
- R7: The pending word follows the mask word and ignores register writes. Each cycle it becomes ((old & ~pend_clr) | pend_set), limited to bits below NUM_VEC.
- R8: The capability is 0x0A, 0x0E, 0x14 or 0x18 bytes long for (32-bit, no mask), (64-bit, no mask), (32-bit, mask) and (64-bit, mask). Dwords beyond it read zero and writes to them have no effect.
- R9: When a write lands in the capability and leaves enable set, an enabled count above log2 NUM_VEC is replaced by log2 NUM_VEC in the same edge.
- R10: When a write lands in the capability and leaves enable set, pending bits at or above 2^(enabled count) are cleared in the same edge. While enable is clear, writes leave the pending word alone.
- R11: msi_en equals the enable bit and intx_deassert is high whenever it is set. vec_grant_log2 is the smaller of the enabled count and log2 NUM_VEC.
- R12: A write changes only the bytes whose byte enable is set.
- R13: reg_rdata loads the addressed dword on the edge where reg_rd is high and holds its value when reg_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_rd | input | 1 | Read strobe for one cycle |
| reg_dw | input | 3 | Dword index from the capability base |
| reg_be | input | 4 | Byte enables for a write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after reg_rd |
| pend_set | input | 32 | Pending bits to set, from delivery logic |
| pend_clr | input | 32 | Pending bits to clear, from delivery logic |
| msi_en | output | 1 | Message interrupts enabled |
| vec_grant_log2 | output | 3 | log2 of the granted vector count |
| intx_deassert | output | 1 | Request to release the legacy INTx line |

## Verification
Every register, as well as msi_en, vec_grant_log2 and intx_deassert, reflects a write, a pending set or clear, or a clamp on the first edge after the stimulus. reg_rdata shows the addressed dword one edge after reg_rd and shows the state from before any write in that same cycle. The bench drives inputs on the falling edge and moves its model on the rising edge. It compares all outputs on the next falling edge, so each result is sampled half a cycle after the edge that produced it. Directed reads then check clamping, pruning, byte enables and out-of-range accesses against hand-derived values.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int MAX_VEC  = 32;
  localparam int DW_IDX_W = 3;

  typedef struct packed {
    logic ctrl;
    logic alo;
    logic ahi;
    logic data;
    logic mask;
    logic pend;
  } msi_sel_t;

  function automatic int cap_len_bytes(bit a64, bit pvm);
    if (pvm) return a64 ? 24 : 20;
    return a64 ? 14 : 10;
  endfunction

  function automatic int data_dw(bit a64);
    return a64 ? 3 : 2;
  endfunction

  function automatic logic [MAX_VEC-1:0] low_ones(int n);
    logic [MAX_VEC-1:0] r;
    for (int i = 0; i < MAX_VEC; i++) r[i] = (i < n);
    return r;
  endfunction
endpackage

// File: rtl/msi_cap_decode.sv
module msi_cap_decode
  import msi_cap_pkg::*;
#(
  parameter bit ADDR64 = 1'b1,
  parameter bit PVM    = 1'b1
) (
  input  logic [DW_IDX_W-1:0] dw,
  input  logic [3:0]          be,
  output msi_sel_t            sel,
  output logic                in_cap
);
  localparam int CAP_LEN = cap_len_bytes(ADDR64, PVM);
  localparam int DDW     = data_dw(ADDR64);

  logic [3:0] byte_hit;

  for (genvar b = 0; b < 4; b++) begin : g_byte
    assign byte_hit[b] = be[b] && ((int'(dw) * 4 + b) < CAP_LEN);
  end

  assign in_cap = |byte_hit;

  always_comb begin
    sel = '0;
    if (in_cap) begin
      sel.ctrl = (int'(dw) == 0);
      sel.alo  = (int'(dw) == 1);
      sel.ahi  = ADDR64 && (int'(dw) == 2);
      sel.data = (int'(dw) == DDW);
      sel.mask = PVM && (int'(dw) == DDW + 1);
      sel.pend = PVM && (int'(dw) == DDW + 2);
    end
  end
endmodule

// File: rtl/msi_cap_ctrl.sv
module msi_cap_ctrl
  import msi_cap_pkg::*;
#(
  parameter int MMC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ctrl,
  input  logic               w_en,
  input  logic [2:0]         w_mme,
  input  logic               wr_land,
  output logic               en_q,
  output logic [2:0]         mme_q,
  output logic [2:0]         grant,
  output logic               prune,
  output logic [MAX_VEC-1:0] prune_mask
);
  localparam logic [2:0] MMC3 = 3'(MMC);

  logic       en_nx;
  logic [2:0] mme_w;
  logic [2:0] mme_nx;

  always_comb begin
    en_nx      = wr_ctrl ? w_en  : en_q;
    mme_w      = wr_ctrl ? w_mme : mme_q;
    prune      = wr_land && en_nx;
    mme_nx     = (prune && (mme_w > MMC3)) ? MMC3 : mme_w;
    prune_mask = low_ones(1 << mme_nx);
  end

  assign grant = (mme_q > MMC3) ? MMC3 : mme_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      mme_q <= 3'd0;
    end else begin
      en_q  <= en_nx;
      mme_q <= mme_nx;
    end
  end
endmodule

// File: rtl/msi_cap_vecregs.sv
module msi_cap_vecregs
  import msi_cap_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter bit PVM     = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_mask,
  input  logic [31:0]        wdata,
  input  logic [31:0]        byte_mask,
  input  logic [MAX_VEC-1:0] pend_set,
  input  logic [MAX_VEC-1:0] pend_clr,
  input  logic               prune,
  input  logic [MAX_VEC-1:0] prune_mask,
  output logic [MAX_VEC-1:0] mask_q,
  output logic [MAX_VEC-1:0] pend_q
);
  localparam logic [MAX_VEC-1:0] VMASK = PVM ? low_ones(NUM_VEC) : '0;

  logic [MAX_VEC-1:0] mask_nx;
  logic [MAX_VEC-1:0] pend_nx;

  always_comb begin
    mask_nx = mask_q;
    if (wr_mask) mask_nx = (mask_q & ~byte_mask) | (wdata & byte_mask);
    mask_nx = mask_nx & VMASK;
    pend_nx = ((pend_q & ~pend_clr) | pend_set) & VMASK;
    if (prune) pend_nx = pend_nx & prune_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      mask_q <= mask_nx;
      pend_q <= pend_nx;
    end
  end
endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_cap_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter bit ADDR64  = 1'b1,
  parameter bit PVM     = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [DW_IDX_W-1:0] reg_dw,
  input  logic [3:0]          reg_be,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [MAX_VEC-1:0]  pend_set,
  input  logic [MAX_VEC-1:0]  pend_clr,
  output logic                msi_en,
  output logic [2:0]          vec_grant_log2,
  output logic                intx_deassert
);
  localparam int          MMC     = $clog2(NUM_VEC);
  localparam logic [31:0] ALO_WM  = 32'hFFFF_FFFC;
  localparam logic [31:0] DATA_WM = 32'h0000_FFFF;

  msi_sel_t wsel, rsel;
  logic     w_in_cap, r_in_cap, wr_land;
  logic [31:0] byte_mask;

  msi_cap_decode #(.ADDR64(ADDR64), .PVM(PVM)) u_wdec (
    .dw(reg_dw), .be(reg_be), .sel(wsel), .in_cap(w_in_cap)
  );
  msi_cap_decode #(.ADDR64(ADDR64), .PVM(PVM)) u_rdec (
    .dw(reg_dw), .be(4'hF), .sel(rsel), .in_cap(r_in_cap)
  );

  assign wr_land = reg_wr && w_in_cap;

  logic unused_pend_wr;
  assign unused_pend_wr = wsel.pend;

  for (genvar b = 0; b < 4; b++) begin : g_bm
    assign byte_mask[8*b +: 8] = {8{reg_be[b]}};
  end

  // address low and message data
  logic [31:0] alo_q, data_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alo_q  <= '0;
      data_q <= '0;
    end else begin
      if (wr_land && wsel.alo)
        alo_q <= (alo_q & ~byte_mask) | (reg_wdata & byte_mask & ALO_WM);
      if (wr_land && wsel.data)
        data_q <= (data_q & ~byte_mask) | (reg_wdata & byte_mask & DATA_WM);
    end
  end

  // address high only in the 64-bit layout
  logic [31:0] ahi_q;
  if (ADDR64) begin : g_ahi
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 ahi_q <= '0;
      else if (wr_land && wsel.ahi) ahi_q <= (ahi_q & ~byte_mask) | (reg_wdata & byte_mask);
    end
  end else begin : g_no_ahi
    assign ahi_q = '0;
  end

  // message control
  logic               en_q, prune;
  logic [2:0]         mme_q;
  logic [MAX_VEC-1:0] prune_mask;

  msi_cap_ctrl #(.MMC(MMC)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl(wr_land && wsel.ctrl && reg_be[2]),
    .w_en(reg_wdata[16]), .w_mme(reg_wdata[22:20]),
    .wr_land(wr_land),
    .en_q(en_q), .mme_q(mme_q), .grant(vec_grant_log2),
    .prune(prune), .prune_mask(prune_mask)
  );

  // mask and pending words
  logic [MAX_VEC-1:0] mask_q, pend_q;

  msi_cap_vecregs #(.NUM_VEC(NUM_VEC), .PVM(PVM)) u_vec (
    .clk(clk), .rst_n(rst_n),
    .wr_mask(wr_land && wsel.mask),
    .wdata(reg_wdata), .byte_mask(byte_mask),
    .pend_set(pend_set), .pend_clr(pend_clr),
    .prune(prune), .prune_mask(prune_mask),
    .mask_q(mask_q), .pend_q(pend_q)
  );

  // read path
  logic [31:0] ctrl_word, rd_mux;
  assign ctrl_word = {7'd0, PVM, ADDR64, mme_q, 3'(MMC), en_q, 16'd0};

  always_comb begin
    rd_mux = '0;
    if (r_in_cap) begin
      if (rsel.ctrl) rd_mux = ctrl_word;
      if (rsel.alo)  rd_mux = alo_q;
      if (rsel.ahi)  rd_mux = ahi_q;
      if (rsel.data) rd_mux = data_q;
      if (rsel.mask) rd_mux = mask_q;
      if (rsel.pend) rd_mux = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  assign msi_en        = en_q;
  assign intx_deassert = en_q;
endmodule

// File: rtl/msi_cap_regs_chk.sv
module msi_cap_regs_chk
  import msi_cap_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter bit ADDR64  = 1'b1,
  parameter bit PVM     = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_rd,
  input logic [DW_IDX_W-1:0] reg_dw,
  input logic [31:0]         reg_rdata,
  input logic                msi_en,
  input logic                intx_deassert,
  input logic [2:0]          vec_grant_log2,
  input logic [2:0]          mme_q,
  input logic [MAX_VEC-1:0]  pend_q,
  input logic                wr_land
);
  localparam logic [2:0] MMC3   = 3'($clog2(NUM_VEC));
  localparam int         MASKDW = data_dw(ADDR64) + 1;

  p_intx_r11: assert property (@(posedge clk) disable iff (!rst_n)
    msi_en |-> intx_deassert);

  p_grant_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    vec_grant_log2 <= MMC3);

  p_clamp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    msi_en |-> (mme_q <= MMC3));

  p_prune_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_land |=> (!msi_en || ((pend_q & ~low_ones(1 << mme_q)) == '0)));

  p_alo_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_dw == 3'd1) |=> (reg_rdata[1:0] == 2'b00));

  p_mask_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && PVM && int'(reg_dw) == MASKDW) |=> ((reg_rdata & ~low_ones(NUM_VEC)) == '0));

  p_rd_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
endmodule

bind msi_cap_regs msi_cap_regs_chk #(.NUM_VEC(NUM_VEC), .ADDR64(ADDR64), .PVM(PVM)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_dw(reg_dw),
  .reg_rdata(reg_rdata), .msi_en(msi_en), .intx_deassert(intx_deassert),
  .vec_grant_log2(vec_grant_log2), .mme_q(mme_q), .pend_q(pend_q),
  .wr_land(wr_land)
);

// File: tb/msi_cap_regs_tb.sv
module msi_cap_regs_tb;
  localparam int NV   = 8;
  localparam int MMC  = 3;
  localparam int CAPB = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_dw = '0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] pend_set = '0, pend_clr = '0;
  logic        msi_en, intx_deassert;
  logic [2:0]  vec_grant_log2;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  msi_cap_regs #(.NUM_VEC(NV), .ADDR64(1'b1), .PVM(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_dw(reg_dw), .reg_be(reg_be), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pend_set(pend_set), .pend_clr(pend_clr),
    .msi_en(msi_en), .vec_grant_log2(vec_grant_log2),
    .intx_deassert(intx_deassert)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // behavioural reference model
  bit          m_en = 0;
  int          m_mme = 0;
  logic [31:0] m_alo = 0, m_ahi = 0, m_data = 0, m_mask = 0, m_pend = 0, m_rdata = 0;

  function automatic logic [31:0] ones_below(int n);
    if (n >= 32) return 32'hFFFF_FFFF;
    return (32'h1 << n) - 32'h1;
  endfunction

  function automatic logic [31:0] m_read(int dw);
    case (dw)
      0: return {7'd0, 1'b1, 1'b1, 3'(m_mme), 3'(MMC), m_en, 16'd0};
      1: return m_alo;
      2: return m_ahi;
      3: return {16'd0, m_data[15:0]};
      4: return m_mask;
      5: return m_pend;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_mme = 0; m_alo = 0; m_ahi = 0; m_data = 0;
      m_mask = 0; m_pend = 0; m_rdata = 0;
    end else begin
      logic [31:0] bm;
      bit landed;
      landed = 0;
      for (int b = 0; b < 4; b++) begin
        bm[8*b +: 8] = {8{reg_be[b]}};
        if (reg_wr && reg_be[b] && (int'(reg_dw) * 4 + b < CAPB)) landed = 1;
      end
      if (reg_rd) m_rdata = m_read(int'(reg_dw));
      if (landed) begin
        case (int'(reg_dw))
          0: if (reg_be[2]) begin m_en = reg_wdata[16]; m_mme = int'(reg_wdata[22:20]); end
          1: m_alo = ((m_alo & ~bm) | (reg_wdata & bm)) & 32'hFFFF_FFFC;
          2: m_ahi = (m_ahi & ~bm) | (reg_wdata & bm);
          3: m_data = ((m_data & ~bm) | (reg_wdata & bm)) & 32'h0000_FFFF;
          4: m_mask = ((m_mask & ~bm) | (reg_wdata & bm)) & ones_below(NV);
          default: ;
        endcase
      end
      m_pend = ((m_pend & ~pend_clr) | pend_set) & ones_below(NV);
      if (landed && m_en) begin
        if (m_mme > MMC) m_mme = MMC;
        m_pend = m_pend & ones_below(1 << m_mme);
      end
    end
  end

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R13 rdata", reg_rdata, m_rdata);
      check("R11 msi_en", 32'(msi_en), 32'(m_en));
      check("R11 intx_deassert", 32'(intx_deassert), 32'(m_en));
      check("R11 grant", 32'(vec_grant_log2), (m_mme > MMC) ? MMC : m_mme);
    end
  end

  task automatic wr(logic [2:0] dw, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    reg_wr = 1'b1; reg_dw = dw; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = '0;
  endtask

  task automatic rd(logic [2:0] dw, logic [31:0] exp, string req);
    @(negedge clk);
    reg_rd = 1'b1; reg_dw = dw;
    @(negedge clk);
    reg_rd = 1'b0;
    check(req, reg_rdata, exp);
  endtask

  task automatic pulse_pend(logic [31:0] s, logic [31:0] c);
    @(negedge clk);
    pend_set = s; pend_clr = c;
    @(negedge clk);
    pend_set = '0; pend_clr = '0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 and R2: reset values and read-only capability fields
    rd(3'd0, 32'h0186_0000, "R1 R2 ctrl after reset");
    rd(3'd1, 32'h0, "R1 addr lo after reset");
    rd(3'd3, 32'h0, "R1 data after reset");
    rd(3'd5, 32'h0, "R1 pending after reset");

    // R2 and R12: bytes other than byte 2 do not touch control
    wr(3'd0, 32'hFFFF_FFFF, 4'b1011);
    rd(3'd0, 32'h0186_0000, "R2 R12 read-only control bytes");

    // R3: oversized enabled count stays unclamped while disabled
    wr(3'd0, 32'h0070_0000, 4'b0100);
    rd(3'd0, 32'h01F6_0000, "R3 enabled count written");
    check("R11 grant limited", 32'(vec_grant_log2), 32'd3);

    // R4: address low and high
    wr(3'd1, 32'hFFFF_FFFF, 4'hF);
    rd(3'd1, 32'hFFFF_FFFC, "R4 addr lo low bits zero");
    wr(3'd2, 32'hA5A5_5A5A, 4'hF);
    rd(3'd2, 32'hA5A5_5A5A, "R4 addr hi");

    // R5 and R12: data width and byte enables
    wr(3'd3, 32'h1234_5678, 4'b0001);
    rd(3'd3, 32'h0000_0078, "R12 byte 0 only");
    wr(3'd3, 32'hFFFF_1234, 4'b1110);
    rd(3'd3, 32'h0000_1278, "R5 upper half reads zero");

    // R6: mask limited to NV bits
    wr(3'd4, 32'hFFFF_FFFF, 4'hF);
    rd(3'd4, 32'h0000_00FF, "R6 mask writable bits");

    // R7: pending via delivery inputs only
    pulse_pend(32'hFFFF_FFFF, 32'h0);
    rd(3'd5, 32'h0000_00FF, "R7 pending set");
    wr(3'd5, 32'h0, 4'hF);
    rd(3'd5, 32'h0000_00FF, "R7 pending ignores writes");
    pulse_pend(32'h0, 32'h0000_000F);
    rd(3'd5, 32'h0000_00F0, "R7 pending clear");

    // R8: beyond capability length
    wr(3'd6, 32'hFFFF_FFFF, 4'hF);
    rd(3'd6, 32'h0, "R8 outside capability reads zero");
    rd(3'd0, 32'h01F6_0000, "R8 outside write no effect");

    // R9: enabling clamps the enabled count
    wr(3'd0, 32'h0071_0000, 4'b0100);
    rd(3'd0, 32'h01B7_0000, "R9 clamp on enable");
    check("R11 msi_en set", 32'(msi_en), 32'd1);
    check("R11 intx deassert", 32'(intx_deassert), 32'd1);

    // R10: pruning to granted vectors
    pulse_pend(32'h0000_00FF, 32'h0);
    rd(3'd5, 32'h0000_00FF, "R10 no prune without write");
    wr(3'd0, 32'h0011_0000, 4'b0100);
    rd(3'd5, 32'h0000_0003, "R10 prune to two vectors");
    wr(3'd0, 32'h0000_0000, 4'b0100);
    pulse_pend(32'h0000_00FF, 32'h0);
    wr(3'd1, 32'h0000_1000, 4'hF);
    rd(3'd5, 32'h0000_00FF, "R10 no prune while disabled");

    // R1: mid-run reset
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd(3'd0, 32'h0186_0000, "R1 ctrl after second reset");
    rd(3'd4, 32'h0, "R1 mask after second reset");
    rd(3'd2, 32'h0, "R1 addr hi after second reset");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule